// File: doc/BRIEF.md
# Unaligned Word Load Assembler

This block sits between a processor load port and a data cache that can only return naturally aligned 32-bit words. A load arrives as a byte address and a request pulse. The block turns it into one or two aligned cache reads. It then rebuilds the requested 32-bit value from the byte lanes of the returned words and presents it with a one-cycle completion pulse.

A load whose low two address bits are zero needs a single read, and the word passes through unchanged. Any other offset needs two reads: first the word that holds the starting byte, then the word four bytes above it. Those two words may sit in different 128-byte cache lines, and either read may stall on a miss for any number of cycles. The control is a four-state machine:

- `ST_IDLE` accepts a request and moves to `ST_READ_FIRST`.
- `ST_READ_FIRST` waits for the acknowledge of the first read. It then moves to `ST_READ_SECOND` for a misaligned load, or to `ST_DONE` for an aligned one.
- `ST_READ_SECOND` waits for the acknowledge of the second read and moves to `ST_DONE`.
- `ST_DONE` presents the result for one cycle and returns to `ST_IDLE`.

A build-time option, `STRICT_ALIGN`, models a processor that supports only aligned word access. In that mode a misaligned request goes from `ST_IDLE` straight to `ST_DONE` with an error flag and issues no cache reads.

Top module: `unaligned_load_unit`

## Requirements
- R1: Every cache read address has bits [1:0] equal to 0; the first read of a load uses the load address with bits [1:0] cleared.
- R2: When load address bits [1:0] are nonzero (and `STRICT_ALIGN`=0), exactly two cache reads are issued, the second at the first read address plus 4, modulo 2^32.
- R3: A misaligned load whose two words lie in different 128-byte lines returns the same correctly assembled value as one inside a single line.
- R4: While `rd_req` is high and `rd_ack` is low, the next cycle keeps `rd_req` high with `rd_addr` unchanged, for any stall length on either read.
- R5: Byte order is little-endian. With offset k = address bits [1:0], `ld_data` equals bits [31:0] of {second word, first word} shifted right by 8*k.
- R6: When address bits [1:0] are 0, exactly one cache read is issued and `ld_data` equals the returned word unchanged.
- R7: `ld_ready` is high exactly when the block is idle. It is low from the cycle after acceptance until completion. `ld_req` asserted while `ld_ready` is low has no effect on reads or results.
- R8: A completed load raises `ld_done` for exactly one cycle, with the result on `ld_data`, `ld_err` low in non-error cases, and `ld_ready` high in the following cycle.
- R9: With `STRICT_ALIGN`=1, a misaligned load issues no cache read and completes with `ld_done` and `ld_err` both high and `ld_data` zero; aligned loads behave as in R6.
- R10: After reset, `ld_ready` is 1 and `rd_req`, `ld_done` and `ld_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_req | input | 1 | Load request, taken when `ld_ready` is high |
| ld_addr | input | 32 | Byte address of the load |
| ld_ready | output | 1 | Block idle, a request will be accepted |
| ld_done | output | 1 | One-cycle completion pulse |
| ld_data | output | 32 | Assembled load value, valid with `ld_done` |
| ld_err | output | 1 | Misalignment error in strict mode, valid with `ld_done` |
| rd_req | output | 1 | Cache read request, held until acknowledged |
| rd_addr | output | 32 | Aligned cache word address |
| rd_ack | input | 1 | Cache read complete, `rd_data` valid |
| rd_data | input | 32 | Cache read word |

## Verification
A wrong state in the machine shows up at the cache port within one cycle. An aligned load that takes a second read, or a misaligned load that takes only one, appears as a wrong read count or a read at the wrong address. A first word captured into the wrong register, or a wrong byte-lane choice, shows up as a rotated or mixed value on `ld_data` in the same cycle as `ld_done`. Line-crossing addresses, address-space wrap and long random stalls on each read separately show whether the block waits on each acknowledge independently.

// File: rtl/ula_pkg.sv
package ula_pkg;

    typedef enum logic [1:0] {
        ST_IDLE        = 2'd0,
        ST_READ_FIRST  = 2'd1,
        ST_READ_SECOND = 2'd2,
        ST_DONE        = 2'd3
    } ula_state_e;

endpackage

// File: rtl/ula_fsm.sv
module ula_fsm
    import ula_pkg::*;
#(
    parameter bit STRICT_ALIGN = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ld_req,
    input  logic       req_misaligned,
    input  logic       held_misaligned,
    input  logic       rd_ack,
    output ula_state_e state
);

    ula_state_e state_nxt;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (ld_req) begin
                    if (STRICT_ALIGN && req_misaligned) begin
                        state_nxt = ST_DONE;
                    end else begin
                        state_nxt = ST_READ_FIRST;
                    end
                end
            end
            ST_READ_FIRST: begin
                if (rd_ack) begin
                    state_nxt = held_misaligned ? ST_READ_SECOND : ST_DONE;
                end
            end
            ST_READ_SECOND: begin
                if (rd_ack) begin
                    state_nxt = ST_DONE;
                end
            end
            ST_DONE: begin
                state_nxt = ST_IDLE;
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/ula_addr_gen.sv
module ula_addr_gen #(
    parameter int ADDR_W = 32,
    parameter int OFS_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic              sel_upper,
    output logic [OFS_W-1:0]  offset,
    output logic [ADDR_W-1:0] rd_addr
);

    localparam int WB_W = ADDR_W - OFS_W;

    logic [WB_W-1:0] word_base_q;
    logic [WB_W-1:0] word_sel;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_base_q <= '0;
            offset      <= '0;
        end else if (capture) begin
            word_base_q <= ld_addr[ADDR_W-1:OFS_W];
            offset      <= ld_addr[OFS_W-1:0];
        end
    end

    // the upper word index wraps at the top of the address space
    assign word_sel = sel_upper ? (word_base_q + WB_W'(1)) : word_base_q;
    assign rd_addr  = {word_sel, {OFS_W{1'b0}}};

endmodule

// File: rtl/ula_merge.sv
module ula_merge #(
    parameter int DATA_W = 32,
    parameter int OFS_W  = 2
) (
    input  logic [DATA_W-1:0] word_lo,
    input  logic [DATA_W-1:0] word_hi,
    input  logic [OFS_W-1:0]  offset,
    output logic [DATA_W-1:0] merged
);

    localparam int LANES = DATA_W / 8;

    logic [2*DATA_W-1:0] pair;
    logic [DATA_W-1:0]   cand [LANES];

    assign pair = {word_hi, word_lo};

    // one candidate per byte offset, little-endian lane order
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign cand[k] = pair[k*8 +: DATA_W];
    end

    assign merged = cand[offset];

endmodule

// File: rtl/unaligned_load_unit.sv
module unaligned_load_unit
    import ula_pkg::*;
#(
    parameter int ADDR_W       = 32,
    parameter int DATA_W       = 32,
    parameter bit STRICT_ALIGN = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_req,
    input  logic [ADDR_W-1:0] ld_addr,
    output logic              ld_ready,
    output logic              ld_done,
    output logic [DATA_W-1:0] ld_data,
    output logic              ld_err,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_ack,
    input  logic [DATA_W-1:0] rd_data
);

    localparam int LANES = DATA_W / 8;
    localparam int OFS_W = $clog2(LANES);

    ula_state_e        state;
    logic              accept;
    logic              req_misaligned;
    logic              held_misaligned;
    logic [OFS_W-1:0]  offset;
    logic [DATA_W-1:0] word_lo_q;
    logic [DATA_W-1:0] word_hi_q;
    logic [DATA_W-1:0] merged;
    logic              err_q;
    logic              sel_upper;

    assign req_misaligned  = (ld_addr[OFS_W-1:0] != '0);
    assign held_misaligned = (offset != '0);
    assign accept          = ld_req && (state == ST_IDLE);

    ula_fsm #(
        .STRICT_ALIGN (STRICT_ALIGN)
    ) u_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .ld_req          (ld_req),
        .req_misaligned  (req_misaligned),
        .held_misaligned (held_misaligned),
        .rd_ack          (rd_ack),
        .state           (state)
    );

    ula_addr_gen #(
        .ADDR_W (ADDR_W),
        .OFS_W  (OFS_W)
    ) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (accept),
        .ld_addr   (ld_addr),
        .sel_upper (sel_upper),
        .offset    (offset),
        .rd_addr   (rd_addr)
    );

    ula_merge #(
        .DATA_W (DATA_W),
        .OFS_W  (OFS_W)
    ) u_merge (
        .word_lo (word_lo_q),
        .word_hi (word_hi_q),
        .offset  (offset),
        .merged  (merged)
    );

    // returned words and error flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_lo_q <= '0;
            word_hi_q <= '0;
            err_q     <= 1'b0;
        end else begin
            if (accept) begin
                err_q <= STRICT_ALIGN && req_misaligned;
            end
            if ((state == ST_READ_FIRST) && rd_ack) begin
                word_lo_q <= rd_data;
            end
            if ((state == ST_READ_SECOND) && rd_ack) begin
                word_hi_q <= rd_data;
            end
        end
    end

    // outputs per state
    always_comb begin
        ld_ready  = 1'b0;
        ld_done   = 1'b0;
        ld_err    = 1'b0;
        ld_data   = '0;
        rd_req    = 1'b0;
        sel_upper = 1'b0;
        unique case (state)
            ST_IDLE: begin
                ld_ready = 1'b1;
            end
            ST_READ_FIRST: begin
                rd_req = 1'b1;
            end
            ST_READ_SECOND: begin
                rd_req    = 1'b1;
                sel_upper = 1'b1;
            end
            ST_DONE: begin
                ld_done = 1'b1;
                ld_err  = err_q;
                ld_data = err_q ? '0 : merged;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/ula_checker.sv
module ula_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ld_ready,
    input logic              ld_done,
    input logic              ld_err,
    input logic              rd_req,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              rd_ack
);

    assert_cache_addr_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> (rd_addr[1:0] == 2'b00));

    assert_second_word_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_ack) |=> (!rd_req || (rd_addr == $past(rd_addr) + ADDR_W'(4))));

    assert_read_held_on_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));

    assert_ready_only_when_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ld_ready |-> (!rd_req && !ld_done));

    assert_done_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ld_done |=> (!ld_done && ld_ready));

    assert_err_only_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ld_err |-> (ld_done && !rd_req));

endmodule

bind unaligned_load_unit ula_checker #(
    .ADDR_W (ADDR_W)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_ready (ld_ready),
    .ld_done  (ld_done),
    .ld_err   (ld_err),
    .rd_req   (rd_req),
    .rd_addr  (rd_addr),
    .rd_ack   (rd_ack)
);

// File: tb/unaligned_load_unit_tb_top.sv
module unaligned_load_unit_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    int          total = 0;
    int          bad = 0;
    bit          finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // ---------------- memory image ----------------
    function automatic logic [7:0] mem_byte(input logic [31:0] a);
        return a[7:0] ^ {a[12:8], a[15:13]} ^ {a[19:16], a[23:20]} ^ a[31:24] ^ 8'h5A;
    endfunction

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        logic [31:0] b;
        b = {a[31:2], 2'b00};
        return {mem_byte(b + 32'd3), mem_byte(b + 32'd2), mem_byte(b + 32'd1), mem_byte(b)};
    endfunction

    function automatic logic [31:0] expect_load(input logic [31:0] a);
        logic [31:0] w0, w1;
        w0 = mem_word({a[31:2], 2'b00});
        w1 = mem_word({a[31:2], 2'b00} + 32'd4);
        case (a[1:0])
            2'd0:    return w0;
            2'd1:    return {w1[7:0],  w0[31:8]};
            2'd2:    return {w1[15:0], w0[31:16]};
            default: return {w1[23:0], w0[31:24]};
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // ---------------- main DUT (unaligned loads) ----------------
    logic        ld_req = 1'b0;
    logic [31:0] ld_addr = '0;
    logic        ld_ready, ld_done, ld_err, rd_req;
    logic [31:0] ld_data, rd_addr;
    logic        rd_ack = 1'b0;
    logic [31:0] rd_data = '0;

    unaligned_load_unit #(
        .ADDR_W (32), .DATA_W (32), .STRICT_ALIGN (1'b0)
    ) dut_i (
        .clk (clk), .rst_n (rst_n),
        .ld_req (ld_req), .ld_addr (ld_addr),
        .ld_ready (ld_ready), .ld_done (ld_done), .ld_data (ld_data), .ld_err (ld_err),
        .rd_req (rd_req), .rd_addr (rd_addr), .rd_ack (rd_ack), .rd_data (rd_data)
    );

    // cache model with random miss stalls
    int unsigned max_stall = 4;
    int unsigned stall_cnt = 0;
    bit          fresh = 1'b1;
    int          n_reads = 0;
    logic [31:0] read_log [4];

    always @(negedge clk) begin
        if (!rst_n || !rd_req) begin
            rd_ack = 1'b0;
            fresh  = 1'b1;
        end else begin
            if (fresh || rd_ack) begin
                stall_cnt = $urandom_range(0, max_stall);
                fresh = 1'b0;
            end
            if (stall_cnt == 0) begin
                rd_ack  = 1'b1;
                rd_data = mem_word(rd_addr);
                if (n_reads < 4) read_log[n_reads] = rd_addr;
                n_reads++;
            end else begin
                stall_cnt--;
                rd_ack  = 1'b0;
                rd_data = $urandom;
            end
        end
    end

    task automatic do_load(input logic [31:0] a, input bit junk);
        logic [31:0] exp;
        int          waited;
        bit          got;
        exp = expect_load(a);
        while (!ld_ready) @(negedge clk);
        n_reads = 0;
        ld_req  = 1'b1;
        ld_addr = a;
        @(negedge clk);
        ld_req = 1'b0;
        got    = 1'b0;
        waited = 0;
        while (!got && waited < 400) begin
            if (ld_done) begin
                got    = 1'b1;
                ld_req = 1'b0;
            end else begin
                check(!ld_ready, "R7 ready low while busy", {31'd0, ld_ready}, 32'd0);
                if (junk) begin
                    ld_req  = $urandom_range(0, 1) == 1;
                    ld_addr = $urandom;
                end
                @(negedge clk);
                waited++;
            end
        end
        ld_req = 1'b0;
        check(got, "R8 load completes", {31'd0, got}, 32'd1);
        if (got) begin
            if (a[1:0] == 2'b00)
                check(ld_data == exp, "R6 aligned passthrough", ld_data, exp);
            else if (a[6:2] == 5'h1F)
                check(ld_data == exp, "R3 line-crossing merge", ld_data, exp);
            else
                check(ld_data == exp, "R5 little-endian merge", ld_data, exp);
            check(ld_err == 1'b0, "R8 no error", {31'd0, ld_err}, 32'd0);
            check(n_reads == ((a[1:0] == 2'b00) ? 1 : 2), "R2 R6 read count", n_reads, (a[1:0] == 2'b00) ? 1 : 2);
            check(read_log[0] == {a[31:2], 2'b00}, "R1 first read address", read_log[0], {a[31:2], 2'b00});
            if (a[1:0] != 2'b00 && n_reads >= 2)
                check(read_log[1] == {a[31:2], 2'b00} + 32'd4, "R2 second read address", read_log[1], {a[31:2], 2'b00} + 32'd4);
            @(negedge clk);
            check(!ld_done && ld_ready, "R8 done is single pulse", {30'd0, ld_done, ld_ready}, 32'd1);
        end
    endtask

    // ---------------- strict DUT ----------------
    logic        s_req = 1'b0;
    logic [31:0] s_addr = '0;
    logic        s_ready, s_done, s_err, s_rd_req;
    logic [31:0] s_data, s_rd_addr, s_rd_data;
    logic        s_rd_ack;
    int          s_reads = 0;

    assign s_rd_ack  = s_rd_req;
    assign s_rd_data = mem_word(s_rd_addr);

    unaligned_load_unit #(
        .ADDR_W (32), .DATA_W (32), .STRICT_ALIGN (1'b1)
    ) dut_strict_i (
        .clk (clk), .rst_n (rst_n),
        .ld_req (s_req), .ld_addr (s_addr),
        .ld_ready (s_ready), .ld_done (s_done), .ld_data (s_data), .ld_err (s_err),
        .rd_req (s_rd_req), .rd_addr (s_rd_addr), .rd_ack (s_rd_ack), .rd_data (s_rd_data)
    );

    always @(posedge clk) if (s_rd_req && s_rd_ack) s_reads++;

    task automatic strict_load(input logic [31:0] a);
        int waited;
        bit mis;
        mis = (a[1:0] != 2'b00);
        while (!s_ready) @(negedge clk);
        s_reads = 0;
        s_req   = 1'b1;
        s_addr  = a;
        @(negedge clk);
        s_req  = 1'b0;
        waited = 0;
        while (!s_done && waited < 50) begin
            @(negedge clk);
            waited++;
        end
        check(s_done, "R9 strict load completes", {31'd0, s_done}, 32'd1);
        check(s_err == mis, "R9 strict error flag", {31'd0, s_err}, {31'd0, mis});
        check(s_data == (mis ? 32'd0 : expect_load(a)), "R9 strict data", s_data, mis ? 32'd0 : expect_load(a));
        check(s_reads == (mis ? 0 : 1), "R9 strict read count", s_reads, mis ? 0 : 1);
        @(negedge clk);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
        finish_run();
    end

    // ---------------- sequence ----------------
    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check(ld_ready && !rd_req && !ld_done && !ld_err, "R10 reset state",
              {28'd0, ld_ready, rd_req, ld_done, ld_err}, 32'h8);
        check(s_ready && !s_rd_req && !s_done && !s_err, "R10 strict reset state",
              {28'd0, s_ready, s_rd_req, s_done, s_err}, 32'h8);

        // all four offsets within one line
        for (int k = 0; k < 4; k++) do_load(32'h0000_0100 + k, 1'b0);
        // R3 line-crossing offsets at a 128-byte boundary
        for (int k = 1; k < 4; k++) do_load(32'h0000_017C + k, 1'b0);
        do_load(32'h1234_5FFD, 1'b0);
        // R2 wrap at top of address space
        do_load(32'hFFFF_FFFF, 1'b0);
        do_load(32'hFFFF_FFFC, 1'b0);
        // R4 long stalls on each read
        max_stall = 20;
        for (int k = 0; k < 4; k++) do_load(32'h0000_8FFC + k, 1'b0);
        max_stall = 4;
        // R7 requests while busy are ignored
        for (int k = 0; k < 8; k++) do_load(32'h0000_2000 + k * 5, 1'b1);

        // random loads, biased toward line edges
        for (int n = 0; n < 300; n++) begin
            logic [31:0] a;
            a = $urandom;
            if ($urandom_range(0, 3) == 0) a[6:2] = 5'h1F;
            max_stall = $urandom_range(0, 6);
            do_load(a, $urandom_range(0, 1) == 1);
        end

        // R9 strict mode
        for (int k = 0; k < 4; k++) strict_load(32'h0000_0200 + k);
        strict_load(32'h0000_027F);

        finish_run();
    end

endmodule